// File: doc/BRIEF.md
# Masked Address Window Remapper

This block sits behind a low-pin-count bus bridge. It turns host firmware-space addresses into addresses on an internal system bus. Two 32-bit configuration words, written through a small register port, set one window.

- The **origin word** gives two things. Its upper halfword is the internal page where the window lands. Its lower halfword is the host page where the window starts.
- The **select word** holds two per-bit masks. Its upper halfword picks the translated page bits that come from the origin. Its lower halfword picks the host page bits that pass through.

The translation merges bits. It never adds an offset. The granularity is 64 KiB: the low halfword of every address passes through unchanged.

Each valid host request gives a registered result one cycle later: a hit flag and the translated address. A request outside the window gives a cleared flag and an all-zero address. A window whose internal offset is not a multiple of its size comes out fragmented or aliased, not shifted. The block reproduces this on purpose, so that software sees the same mapping the hardware makes.

Top module: `fw_window_remap`

## Requirements
- R1: During reset and on the first cycle after it, `rsp_valid`, `rsp_hit` and `rsp_addr` are all zero. Reset also clears the origin and select words to zero. With both words zero, a request whose host page is 0x0000 hits and passes through unchanged.
- R2: On a hit, the translated upper halfword `rsp_addr[31:16]` is (origin[31:16] AND select[31:16]) OR (`req_addr[31:16]` AND select[15:0]).
- R3: On a hit, `rsp_addr[15:0]` equals `req_addr[15:0]` of the same request.
- R4: A request hits when `req_addr[31:16]` equals origin[15:0] in every bit position where select[15:0] is 0. Positions where select[15:0] is 1 are not compared.
- R5: A request that misses gives `rsp_hit` = 0 and `rsp_addr` = 0.
- R6: `rsp_valid` is `req_valid` delayed by one clock. In a cycle with no request, `rsp_hit` and `rsp_addr` keep their last values.
- R7: A configuration write only affects requests sampled after the write edge. A request sampled on the same edge as the write still uses the old value.
- R8: A write with `cfg_sel` = 0 replaces only the origin word. A write with `cfg_sel` = 1 replaces only the select word.
- R9: The merge uses no carry. Origin page bits outside select[31:16] are dropped. If a bit is set in both select halves, the origin bit and the host bit are ORed, so several host pages can alias to one internal page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | Word select: 0 origin, 1 select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Host address valid |
| req_addr | input | 32 | Host firmware-space address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | Request fell inside the window |
| rsp_addr | output | 32 | Translated internal address, zero on a miss |

## Verification
A table of configurations and host addresses drives the bench:

- A typical 1 MiB window tested at its first, middle and last page separates the pass-through bits from the kept bits.
- A host page just outside that window shows the hit compare against the unmasked bits.
- The all-zero configuration and the full pass-through configuration mark the two ends of the select range.
- A misaligned origin and an overlapping select pattern show the carry-free merge dropping and aliasing pages.

Directed tests add:

- a write on the same edge as a request, to show which value each request sees;
- a write to one word only, to show that the other word is left alone;
- idle cycles after a request, to show the outputs are held;
- a second reset, to show the configuration words are cleared.

// File: rtl/fw_window_remap.sv
module fw_window_remap #(
  parameter int HW = 16,
  localparam int AW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [AW-1:0] rsp_addr
);

  logic [AW-1:0] base_q, mask_q;

  logic [HW-1:0] dst_pg, src_pg, keep_m, pass_m, host_pg, xl_pg;
  logic          win_hit;

  assign dst_pg  = base_q[AW-1:HW];
  assign src_pg  = base_q[HW-1:0];
  assign keep_m  = mask_q[AW-1:HW];
  assign pass_m  = mask_q[HW-1:0];
  assign host_pg = req_addr[AW-1:HW];

  assign win_hit = ((host_pg ^ src_pg) & ~pass_m) == '0;
  assign xl_pg   = (dst_pg & keep_m) | (host_pg & pass_m);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) mask_q <= cfg_wdata;
      else         base_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit  <= win_hit;
        rsp_addr <= win_hit ? {xl_pg, req_addr[HW-1:0]} : '0;
      end
    end
  end

endmodule

module fw_window_remap_chk #(
  parameter int HW = 16,
  localparam int AW = 2 * HW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [AW-1:0] rsp_addr,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] mask_q
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && !rsp_hit && rsp_addr == '0));

  p_low_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_addr[HW-1:0] == $past(req_addr[HW-1:0])));

  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_addr == '0);

  p_valid_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_hit)));

  p_sel_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (base_q == $past(cfg_wdata) && $stable(mask_q)));

  p_sel_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> (mask_q == $past(cfg_wdata) && $stable(base_q)));

endmodule

bind fw_window_remap fw_window_remap_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
  .base_q(base_q), .mask_q(mask_q)
);

// File: tb/fw_window_remap_tb.sv
module fw_window_remap_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fw_window_remap u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
  );

  // {origin, select, host address, expected hit, expected address}
  localparam int NV = 12;
  localparam logic [128:0] VEC [NV] = '{
    {32'h9800_0FF0, 32'hFFF0_000F, 32'h0FF3_ABCD, 1'b1, 32'h9803_ABCD}, // R2 R3
    {32'h9800_0FF0, 32'hFFF0_000F, 32'h0FE3_ABCD, 1'b0, 32'h0000_0000}, // R4 R5
    {32'h9800_0FF0, 32'hFFF0_000F, 32'h0FFF_FFFF, 1'b1, 32'h980F_FFFF}, // R2 top
    {32'h9800_0FF0, 32'hFFF0_000F, 32'h0FF0_0000, 1'b1, 32'h9800_0000}, // R2 bottom
    {32'h0000_0000, 32'h0000_0000, 32'h0000_1234, 1'b1, 32'h0000_1234}, // R4
    {32'h0000_0000, 32'h0000_0000, 32'h0001_0000, 1'b0, 32'h0000_0000}, // R5
    {32'h1234_5678, 32'h0000_FFFF, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF}, // R4 all pass
    {32'hA5A5_0042, 32'hFFFF_0000, 32'h0042_0007, 1'b1, 32'hA5A5_0007}, // R2 keep all
    {32'hA5A5_0042, 32'hFFFF_0000, 32'h0043_0007, 1'b0, 32'h0000_0000}, // R5
    {32'h1001_0020, 32'hFFFE_0001, 32'h0021_1111, 1'b1, 32'h1001_1111}, // R9 dropped
    {32'h1001_0020, 32'hFFFE_0001, 32'h0020_2222, 1'b1, 32'h1000_2222}, // R9 dropped
    {32'h1001_0020, 32'hFFFF_0001, 32'h0020_3333, 1'b1, 32'h1001_3333}  // R9 alias
  };

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic request(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 in reset", {rsp_valid, rsp_hit, rsp_addr[30:0]}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {rsp_valid, rsp_hit, rsp_addr[30:0]}, '0);
    request(32'h0000_ABCD);
    chk("R1 zero config", {rsp_hit, rsp_addr}, {1'b1, 32'h0000_ABCD});

    for (int i = 0; i < NV; i++) begin
      cfg_write(1'b0, VEC[i][128:97]);
      cfg_write(1'b1, VEC[i][96:65]);
      request(VEC[i][64:33]);
      chk($sformatf("R2/R3/R4/R5/R9 vector %0d", i),
          {rsp_hit, rsp_addr}, {VEC[i][32], VEC[i][31:0]});
      chk($sformatf("R6 valid vector %0d", i), {32'b0, rsp_valid}, 33'd1);
    end

    // R9 alias: a second host page folds onto the same internal page
    request(32'h0021_4444);
    chk("R9 alias second page", {rsp_hit, rsp_addr}, {1'b1, 32'h1001_4444});

    // R6: idle cycles hold the outputs and drop valid
    repeat (3) @(negedge clk);
    chk("R6 hold", {rsp_hit, rsp_addr}, {1'b1, 32'h1001_4444});
    chk("R6 idle valid", {32'b0, rsp_valid}, 33'd0);

    // R7: a write on the same edge as a request is not yet seen
    cfg_write(1'b0, 32'h9800_0FF0);
    cfg_write(1'b1, 32'hFFF0_000F);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h5500_0FF0;
    req_valid = 1'b1; req_addr = 32'h0FF3_0001;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R7 same edge old origin", {rsp_hit, rsp_addr}, {1'b1, 32'h9803_0001});
    request(32'h0FF3_0001);
    chk("R7 next request new origin", {rsp_hit, rsp_addr}, {1'b1, 32'h5503_0001});

    // R8: a select write leaves the origin word alone
    cfg_write(1'b0, 32'hA5A5_0042);
    cfg_write(1'b1, 32'hFFFF_0000);
    cfg_write(1'b1, 32'hFF00_0000);
    request(32'h0042_0001);
    chk("R8 origin kept, select replaced", {rsp_hit, rsp_addr}, {1'b1, 32'hA500_0001});
    cfg_write(1'b0, 32'h3C3C_0042);
    request(32'h0042_0002);
    chk("R8 origin replaced, select kept", {rsp_hit, rsp_addr}, {1'b1, 32'h3C00_0002});

    // R1: a second reset clears both words
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 outputs after second reset", {rsp_valid, rsp_hit, rsp_addr[30:0]}, '0);
    request(32'h0000_5A5A);
    chk("R1 words cleared", {rsp_hit, rsp_addr}, {1'b1, 32'h0000_5A5A});
    request(32'h0042_0003);
    chk("R1 words cleared miss", {rsp_hit, rsp_addr}, {1'b0, 32'h0});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule